// File: doc/BRIEF.md
# Supervisor State-Save Fault Checker

This block decides, for one supervisor extended-state save request, whether the save may go ahead or which fault must be raised instead. The decode stage presents a request strobe along with the processor mode, the current privilege level, the effective address of the save area, and a set of precomputed flags. These flags cover segment-limit violations, stack-segment use, page faults, control-register bits, feature-enumeration bits and the presence of a lock prefix.

The rule set depends on the mode: real mode, protected mode (virtual-8086 and compatibility share the protected rules), and 64-bit mode. The block evaluates every fault condition in parallel and then picks one by a fixed priority. One cycle after the strobe it reports either a single fault class or a proceed pulse. Segment-limit arithmetic, page walks and the save itself are done elsewhere.

Top module: `xsf_save_guard`

## Requirements
- R1: Exactly one cycle after a clock edge that samples `req_valid` high, exactly one of `fault_valid` and `proceed` is high. In every other cycle, and while in reset, both are low and `fault_code` is 0.
- R2: An undefined-opcode fault (`fault_code` 1) is raised when `lock_prefix` is 1 or when any of `cpuid_save`, `cpuid_sup_save` or `cr4_osxsave` is 0.
- R3: A device-not-available fault (`fault_code` 2) is raised when `cr0_ts` is 1.
- R4: `cpu_mode` encodes real as 00, protected as 01, 64-bit as 10 and compatibility as 11. In modes 01, 10 and 11 a nonzero `cpl` raises general protection (`fault_code` 3). In mode 00 `cpl` is ignored.
- R5: In every mode, an address whose low 6 bits are not all zero (not a multiple of 64) raises general protection.
- R6: In 64-bit mode, an address whose bits 63:47 are not all equal is non-canonical. It raises a stack fault (`fault_code` 4) when `stack_seg` is 1 and general protection otherwise. `limit_viol` is ignored in this mode.
- R7: In real mode, a save area of `SAVE_BYTES` (576) bytes whose last byte lies beyond offset FFFFh raises general protection. `limit_viol` and `page_fault` are ignored in this mode.
- R8: In protected and compatibility modes, `limit_viol` raises a stack fault when `stack_seg` is 1 and general protection when it is 0.
- R9: In modes 01, 10 and 11, `page_fault` raises a page fault (`fault_code` 5).
- R10: When several faults apply, the reported class follows the priority undefined-opcode, device-not-available, general protection, stack fault, page fault. A proceed result carries `fault_code` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe; all other inputs are sampled with it |
| cpu_mode | input | 2 | 00 real, 01 protected, 10 64-bit, 11 compatibility |
| cpl | input | 2 | Current privilege level |
| eff_addr | input | ADDR_W | Effective address of the save area |
| stack_seg | input | 1 | Access goes through the stack segment |
| limit_viol | input | 1 | Precomputed segment-limit violation |
| page_fault | input | 1 | Precomputed page-fault indication |
| lock_prefix | input | 1 | Lock prefix present |
| cr0_ts | input | 1 | Task-switched control bit |
| cr4_osxsave | input | 1 | OS extended-state enable bit |
| cpuid_save | input | 1 | General extended-save feature enumerated |
| cpuid_sup_save | input | 1 | Supervisor-save feature enumerated |
| fault_valid | output | 1 | A fault is reported this cycle |
| fault_code | output | 3 | 0 none, 1 undefined opcode, 2 device not available, 3 general protection, 4 stack fault, 5 page fault |
| proceed | output | 1 | The save may proceed |

## Verification
The assertions assume every input carries a known value in any cycle where `req_valid` is high. They also assume the upstream flags are consistent with the request they accompany. The properties look at inputs one cycle back, so they depend on those inputs being sampled together with the strobe. The bench changes every input only on the falling clock edge and drives all of them on every request, so nothing is left undefined at a sampling edge. Its random addresses are drawn from bands near the alignment, real-mode and canonical boundaries, so those properties are actually exercised.

// File: rtl/xsf_pkg.sv
package xsf_pkg;

    typedef enum logic [1:0] {
        MODE_REAL   = 2'b00,
        MODE_PROT   = 2'b01,
        MODE_LONG   = 2'b10,
        MODE_COMPAT = 2'b11
    } cpu_mode_e;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_UD   = 3'd1,
        FLT_NM   = 3'd2,
        FLT_GP   = 3'd3,
        FLT_SS   = 3'd4,
        FLT_PF   = 3'd5
    } fault_e;

    localparam int N_CLASS = 5;

    // msb = highest priority
    typedef struct packed {
        logic ud;
        logic nm;
        logic gp;
        logic ss;
        logic pf;
    } fault_vec_t;

    typedef struct packed {
        logic   valid;
        logic   proceed;
        fault_e code;
    } result_t;

endpackage

// File: rtl/xsf_cond.sv
module xsf_cond
    import xsf_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int VA_BITS     = 48,
    parameter int ALIGN_BYTES = 64,
    parameter int SAVE_BYTES  = 576
) (
    input  logic [1:0]        cpu_mode,
    input  logic [1:0]        cpl,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic              stack_seg,
    input  logic              limit_viol,
    input  logic              page_fault,
    input  logic              lock_prefix,
    input  logic              cr0_ts,
    input  logic              cr4_osxsave,
    input  logic              cpuid_save,
    input  logic              cpuid_sup_save,
    output fault_vec_t        cond
);

    localparam int          ALIGN_BITS = $clog2(ALIGN_BYTES);
    localparam logic [16:0] LAST_OFS   = 17'(SAVE_BYTES - 1);

    logic canon;
    logic misalign;
    logic real_over;
    logic is_real;
    logic is_long;
    logic is_seg;
    logic priv_bad;
    cpu_mode_e mode;

    generate
        if (VA_BITS >= ADDR_W) begin : g_no_canon
            assign canon = 1'b1;
        end else begin : g_canon
            logic [ADDR_W-VA_BITS:0] top_bits;
            assign top_bits = eff_addr[ADDR_W-1:VA_BITS-1];
            assign canon    = (&top_bits) | ~(|top_bits);
        end
    endgenerate

    always_comb begin
        logic [16:0] last_byte;
        mode      = cpu_mode_e'(cpu_mode);
        is_real   = (mode == MODE_REAL);
        is_long   = (mode == MODE_LONG);
        is_seg    = (mode == MODE_PROT) || (mode == MODE_COMPAT);
        misalign  = |eff_addr[ALIGN_BITS-1:0];
        last_byte = {1'b0, eff_addr[15:0]} + LAST_OFS;
        real_over = last_byte[16] | (|eff_addr[ADDR_W-1:16]);
        priv_bad  = !is_real && (cpl != 2'd0);

        cond.ud = lock_prefix | ~cr4_osxsave | ~cpuid_save | ~cpuid_sup_save;
        cond.nm = cr0_ts;
        cond.gp = misalign
                | priv_bad
                | (is_real & real_over)
                | (is_long & ~canon & ~stack_seg)
                | (is_seg & limit_viol & ~stack_seg);
        cond.ss = (is_long & ~canon & stack_seg)
                | (is_seg & limit_viol & stack_seg);
        cond.pf = ~is_real & page_fault;
    end

endmodule

// File: rtl/xsf_prio.sv
module xsf_prio
    import xsf_pkg::*;
(
    input  fault_vec_t cond,
    output fault_e     code,
    output logic       any
);

    always_comb begin
        logic [N_CLASS-1:0] vec;
        logic               found;
        vec   = cond;
        found = 1'b0;
        code  = FLT_NONE;
        for (int i = N_CLASS - 1; i >= 0; i--) begin
            if (vec[i] && !found) begin
                found = 1'b1;
                code  = fault_e'(3'(N_CLASS - i));
            end
        end
        any = found;
    end

endmodule

// File: rtl/xsf_save_guard.sv
module xsf_save_guard
    import xsf_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int VA_BITS     = 48,
    parameter int ALIGN_BYTES = 64,
    parameter int SAVE_BYTES  = 576
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        cpu_mode,
    input  logic [1:0]        cpl,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic              stack_seg,
    input  logic              limit_viol,
    input  logic              page_fault,
    input  logic              lock_prefix,
    input  logic              cr0_ts,
    input  logic              cr4_osxsave,
    input  logic              cpuid_save,
    input  logic              cpuid_sup_save,
    output logic              fault_valid,
    output logic [2:0]        fault_code,
    output logic              proceed
);

    fault_vec_t cond;
    fault_e     sel_code;
    logic       any_fault;
    result_t    res_d;
    result_t    res_q;

    xsf_cond #(
        .ADDR_W      (ADDR_W),
        .VA_BITS     (VA_BITS),
        .ALIGN_BYTES (ALIGN_BYTES),
        .SAVE_BYTES  (SAVE_BYTES)
    ) u_cond (
        .cpu_mode       (cpu_mode),
        .cpl            (cpl),
        .eff_addr       (eff_addr),
        .stack_seg      (stack_seg),
        .limit_viol     (limit_viol),
        .page_fault     (page_fault),
        .lock_prefix    (lock_prefix),
        .cr0_ts         (cr0_ts),
        .cr4_osxsave    (cr4_osxsave),
        .cpuid_save     (cpuid_save),
        .cpuid_sup_save (cpuid_sup_save),
        .cond           (cond)
    );

    xsf_prio u_prio (
        .cond (cond),
        .code (sel_code),
        .any  (any_fault)
    );

    always_comb begin
        res_d = '{valid: 1'b0, proceed: 1'b0, code: FLT_NONE};
        if (req_valid) begin
            res_d.valid   = any_fault;
            res_d.proceed = ~any_fault;
            res_d.code    = any_fault ? sel_code : FLT_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '{valid: 1'b0, proceed: 1'b0, code: FLT_NONE};
        end else begin
            res_q <= res_d;
        end
    end

    assign fault_valid = res_q.valid;
    assign proceed     = res_q.proceed;
    assign fault_code  = res_q.code;

endmodule

// File: rtl/xsf_save_guard_chk.sv
module xsf_save_guard_chk #(
    parameter int ADDR_W      = 64,
    parameter int ALIGN_BYTES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] eff_addr,
    input logic              lock_prefix,
    input logic              cr0_ts,
    input logic              cr4_osxsave,
    input logic              cpuid_save,
    input logic              cpuid_sup_save,
    input logic              fault_valid,
    input logic [2:0]        fault_code,
    input logic              proceed
);

    localparam int ALIGN_BITS = $clog2(ALIGN_BYTES);

    logic feat_ok;
    assign feat_ok = !lock_prefix && cr4_osxsave && cpuid_save && cpuid_sup_save;

    assert_one_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (fault_valid ^ proceed));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!fault_valid && !proceed && fault_code == 3'd0));

    assert_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !feat_ok) |=> (fault_valid && fault_code == 3'd1));

    assert_devna_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && feat_ok && cr0_ts) |=> (fault_valid && fault_code == 3'd2));

    assert_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && feat_ok && !cr0_ts && (|eff_addr[ALIGN_BITS-1:0]))
        |=> (fault_valid && fault_code == 3'd3));

    assert_proceed_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        proceed |-> (fault_code == 3'd0));

    assert_fault_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_code >= 3'd1 && fault_code <= 3'd5));

endmodule

bind xsf_save_guard xsf_save_guard_chk #(
    .ADDR_W      (ADDR_W),
    .ALIGN_BYTES (ALIGN_BYTES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .eff_addr       (eff_addr),
    .lock_prefix    (lock_prefix),
    .cr0_ts         (cr0_ts),
    .cr4_osxsave    (cr4_osxsave),
    .cpuid_save     (cpuid_save),
    .cpuid_sup_save (cpuid_sup_save),
    .fault_valid    (fault_valid),
    .fault_code     (fault_code),
    .proceed        (proceed)
);

// File: tb/sim_xsf_save_guard.sv
`timescale 1ns/1ps
module sim_xsf_save_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  cpu_mode = 2'd0;
    logic [1:0]  cpl = 2'd0;
    logic [63:0] eff_addr = 64'd0;
    logic        stack_seg = 1'b0;
    logic        limit_viol = 1'b0;
    logic        page_fault = 1'b0;
    logic        lock_prefix = 1'b0;
    logic        cr0_ts = 1'b0;
    logic        cr4_osxsave = 1'b1;
    logic        cpuid_save = 1'b1;
    logic        cpuid_sup_save = 1'b1;
    logic        fault_valid;
    logic [2:0]  fault_code;
    logic        proceed;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    xsf_save_guard u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cpu_mode(cpu_mode),
        .cpl(cpl), .eff_addr(eff_addr), .stack_seg(stack_seg),
        .limit_viol(limit_viol), .page_fault(page_fault),
        .lock_prefix(lock_prefix), .cr0_ts(cr0_ts), .cr4_osxsave(cr4_osxsave),
        .cpuid_save(cpuid_save), .cpuid_sup_save(cpuid_sup_save),
        .fault_valid(fault_valid), .fault_code(fault_code), .proceed(proceed)
    );

    function automatic logic [2:0] ref_code(
        input logic [1:0] m, input logic [1:0] pl, input logic [63:0] a,
        input logic ss, input logic lim, input logic pf, input logic lk,
        input logic ts, input logic osx, input logic fs, input logic fp);
        logic gp, sf;
        logic [16:0] top;
        if (lk || !osx || !fs || !fp) return 3'd1;
        if (ts) return 3'd2;
        gp = (a % 64) != 0;
        sf = 1'b0;
        top = a[63:47];
        case (m)
            2'd0: if (a > 64'hFFFF - 64'd575) gp = 1'b1;
            2'd2: begin
                if (pl != 0) gp = 1'b1;
                if (!(top == 17'd0 || top == 17'h1FFFF)) begin
                    if (ss) sf = 1'b1; else gp = 1'b1;
                end
            end
            default: begin
                if (pl != 0) gp = 1'b1;
                if (lim) begin
                    if (ss) sf = 1'b1; else gp = 1'b1;
                end
            end
        endcase
        if (gp) return 3'd3;
        if (sf) return 3'd4;
        if (m != 2'd0 && pf) return 3'd5;
        return 3'd0;
    endfunction

    task automatic check_out(input string tag, input logic [2:0] exp);
        n_run++;
        if (fault_valid !== (exp != 0) || proceed !== (exp == 0) || fault_code !== exp) begin
            n_fail++;
            $display("FAIL %s: valid=%0b proceed=%0b code=%0d expected valid=%0b proceed=%0b code=%0d",
                     tag, fault_valid, proceed, fault_code, exp != 0, exp == 0, exp);
        end
    endtask

    task automatic run(input string tag, input logic [1:0] m, input logic [1:0] pl,
                       input logic [63:0] a, input logic ss, input logic lim,
                       input logic pf, input logic lk, input logic ts,
                       input logic osx, input logic fs, input logic fp);
        @(negedge clk);
        cpu_mode = m; cpl = pl; eff_addr = a; stack_seg = ss; limit_viol = lim;
        page_fault = pf; lock_prefix = lk; cr0_ts = ts; cr4_osxsave = osx;
        cpuid_save = fs; cpuid_sup_save = fp; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_out(tag, ref_code(m, pl, a, ss, lim, pf, lk, ts, osx, fs, fp));
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        n_run++;
        if (fault_valid !== 1'b0 || proceed !== 1'b0 || fault_code !== 3'd0) begin
            n_fail++;
            $display("FAIL %s: valid=%0b proceed=%0b code=%0d expected all zero",
                     tag, fault_valid, proceed, fault_code);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        idle_check("R1 reset state");
        rst_n = 1'b1;
        idle_check("R1 after reset");

        // base proceed in every mode
        for (int m = 0; m < 4; m++)
            run("R1 proceed", 2'(m), 2'd0, 64'h1000, 0, 0, 0, 0, 0, 1, 1, 1);
        idle_check("R1 idle after request");

        run("R2 lock", 2'd1, 2'd0, 64'h1000, 0, 0, 0, 1, 0, 1, 1, 1);
        run("R2 osxsave clear", 2'd2, 2'd0, 64'h1000, 0, 0, 0, 0, 0, 0, 1, 1);
        run("R2 save feature clear", 2'd0, 2'd0, 64'h1000, 0, 0, 0, 0, 0, 1, 0, 1);
        run("R2 R10 sup feature clear over ts", 2'd1, 2'd3, 64'h1001, 0, 0, 0, 0, 1, 1, 1, 0);

        run("R3 ts", 2'd2, 2'd0, 64'h1000, 0, 0, 0, 0, 1, 1, 1, 1);
        run("R3 R10 ts over cpl", 2'd1, 2'd3, 64'h1000, 0, 0, 1, 0, 1, 1, 1, 1);

        run("R4 cpl3 protected", 2'd1, 2'd3, 64'h1000, 0, 0, 0, 0, 0, 1, 1, 1);
        run("R4 cpl1 64-bit", 2'd2, 2'd1, 64'h1000, 0, 0, 0, 0, 0, 1, 1, 1);
        run("R4 cpl2 compat", 2'd3, 2'd2, 64'h1000, 0, 0, 0, 0, 0, 1, 1, 1);
        run("R4 cpl3 real ignored", 2'd0, 2'd3, 64'h1000, 0, 0, 0, 0, 0, 1, 1, 1);

        run("R5 misaligned real", 2'd0, 2'd0, 64'h1020, 0, 0, 0, 0, 0, 1, 1, 1);
        run("R5 misaligned 64-bit", 2'd2, 2'd0, 64'h1001, 0, 0, 0, 0, 0, 1, 1, 1);
        run("R5 misaligned protected", 2'd1, 2'd0, 64'h1008, 1, 1, 1, 0, 0, 1, 1, 1);

        run("R6 noncanonical gp", 2'd2, 2'd0, 64'h0000_8000_0000_0000, 0, 0, 0, 0, 0, 1, 1, 1);
        run("R6 noncanonical stack", 2'd2, 2'd0, 64'h0000_8000_0000_0000, 1, 0, 0, 0, 0, 1, 1, 1);
        run("R6 canonical high", 2'd2, 2'd0, 64'hFFFF_8000_0000_0000, 1, 0, 0, 0, 0, 1, 1, 1);
        run("R6 noncanonical top", 2'd2, 2'd0, 64'h7FFF_FFFF_FFFF_FFC0, 0, 0, 0, 0, 0, 1, 1, 1);
        run("R6 limit ignored", 2'd2, 2'd0, 64'h2000, 1, 1, 0, 0, 0, 1, 1, 1);

        run("R7 past FFFFh", 2'd0, 2'd0, 64'hFE00, 0, 0, 0, 0, 0, 1, 1, 1);
        run("R7 ends at FFFFh", 2'd0, 2'd0, 64'hFDC0, 0, 0, 0, 0, 0, 1, 1, 1);
        run("R7 above 16 bits", 2'd0, 2'd0, 64'h10000, 0, 0, 0, 0, 0, 1, 1, 1);
        run("R7 limit and pf ignored", 2'd0, 2'd0, 64'h0040, 1, 1, 1, 0, 0, 1, 1, 1);

        run("R8 limit stack", 2'd1, 2'd0, 64'h1000, 1, 1, 0, 0, 0, 1, 1, 1);
        run("R8 limit data", 2'd1, 2'd0, 64'h1000, 0, 1, 0, 0, 0, 1, 1, 1);
        run("R8 compat limit stack", 2'd3, 2'd0, 64'h1000, 1, 1, 0, 0, 0, 1, 1, 1);

        run("R9 pf protected", 2'd1, 2'd0, 64'h1000, 0, 0, 1, 0, 0, 1, 1, 1);
        run("R9 pf 64-bit", 2'd2, 2'd0, 64'h1000, 0, 0, 1, 0, 0, 1, 1, 1);

        run("R10 gp over stack", 2'd2, 2'd0, 64'h0000_8000_0000_0004, 1, 0, 0, 0, 0, 1, 1, 1);
        run("R10 stack over pf", 2'd1, 2'd0, 64'h1000, 1, 1, 1, 0, 0, 1, 1, 1);
        run("R10 gp over pf", 2'd2, 2'd2, 64'h1000, 0, 0, 1, 0, 0, 1, 1, 1);

        for (int i = 0; i < 400; i++) begin
            logic [63:0] a;
            case ($urandom_range(0, 3))
                0: a = {48'd0, 10'($urandom), 6'd0};
                1: a = 64'hFC00 + 64'($urandom_range(0, 1023));
                2: a = {$urandom_range(0, 1) ? 17'h1FFFF : 17'h00000,
                        47'({$urandom, $urandom})} ^ ($urandom_range(0, 3) == 0 ? 64'h0000_8000_0000_0000 : 64'd0);
                default: a = {$urandom, $urandom};
            endcase
            if ($urandom_range(0, 1) == 0) a[5:0] = 6'd0;
            run("R10 random", 2'($urandom), ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'd0,
                a, 1'($urandom), ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0),
                ($urandom_range(0, 15) == 0), ($urandom_range(0, 9) == 0),
                ($urandom_range(0, 15) != 0), ($urandom_range(0, 15) != 0),
                ($urandom_range(0, 15) != 0));
            if (i % 50 == 0) idle_check("R1 random idle");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule